// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address from a single stream into a physical address. It does this by reading two 8-byte descriptors from memory over a 64-bit read port with request, grant and data-valid handshakes. The address is split into a base-register selector, a first-level index, a second-level index and a 14-bit offset within a 16 KiB page. The first-level descriptor names a second-level table. The second-level descriptor names the physical page, and it may also limit which part of that page can be accessed.

Each request is answered with exactly one response, either a physical address or a fault. When bypass is set, the request skips the walk and the address passes straight through. When translation is disabled, or the selected base register is not valid, the request faults without touching memory. Physical page addresses in descriptors are stored shifted right by `PA_SHIFT` (0 or 4), and the walker shifts them back before use. Only one walk is in flight at any time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `mem_req` and `rsp_valid` are 0.
- R2: A request is taken on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` stays 1 from the next cycle up to and including the response cycle. While `busy` is 1, `req_valid` is ignored and has no effect on the response.
- R3: If `cfg_bypass` is 1 when a request is taken, the response has no fault, `rsp_pa` equals `req_va` zero-extended, and no memory read is made. This holds whatever `cfg_xlate_en` is.
- R4: If bypass is 0 and `cfg_xlate_en` is 0, the response is a fault and no memory read is made.
- R5: The base register is chosen by `va[31:30]`; register k sits in `cfg_ttbr[32k+31:32k]`. Bit 31 of the register is its valid flag, and if it is 0 the request faults with no memory read. Otherwise the first read goes to `{ttbr[27:0], 12'b0} + 8*va[29:25]`.
- R6: A first-level descriptor leads to a second read only if its bits 1:0 are 2'b11; any other value faults after one read. The table address is `({desc[39:0], PA_SHIFT zeros} truncated to 40 bits)` with bits 13:0 cleared. The second read goes to that table address plus `8*va[24:14]`.
- R7: A second-level descriptor with bit 0 clear faults, and this includes the all-zero descriptor.
- R8: When bit 1 of the second-level descriptor (full page) is clear, the access faults if `va[13:2]` is less than `desc[63:52]` or greater than `desc[51:40]`. When bit 1 is set, the bounds are not checked.
- R9: A successful translation returns a physical page built from the second-level descriptor in the same way as R6, OR'd with `va[13:0]`. A faulting response drives `rsp_pa` to 0.
- R10: `mem_req` stays 1 with a stable `mem_addr` until a cycle with `mem_gnt`. The read data is taken on the first `mem_rvalid` after the grant cycle, and `mem_addr` is 8-byte aligned.
- R11: `rsp_valid` lasts exactly one cycle per request, and `req_ready` is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_xlate_en | input | 1 | Translation enable for the stream |
| cfg_bypass | input | 1 | Pass addresses through untranslated |
| cfg_ttbr | input | NUM_TTBR*TTBR_W | Table base registers, valid flag in the top bit |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | VA_W | Device virtual address |
| req_ready | output | 1 | Walker idle and able to take a request |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | PA_W | Descriptor byte address |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor read data |
| rsp_valid | output | 1 | Response strobe (done) |
| rsp_fault | output | 1 | Translation fault |
| rsp_pa | output | PA_W | Translated physical address |

## Verification
A new request can arrive in the same cycle as the response to the previous one. In that cycle the walker is still busy, so the new request must be dropped and not taken a cycle early. The bench provokes this by holding `req_valid` high with a different address for the whole walk, right up to the response cycle. It then judges the outcome by checking that exactly one response appears, that its address comes from the first request, and that `req_ready` returns in the next cycle. The same combination is run against bypass, early faults and full two-read walks with different grant and data latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   localparam int unsigned DESC_W = 64;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_REQ,
      ST_L1_WAIT,
      ST_L2_REQ,
      ST_L2_WAIT,
      ST_RESP
   } walk_state_e;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PAGE_BITS = 14,
   parameter int unsigned NUM_TTBR  = 4,
   parameter int unsigned TTBR_W    = 32,
   parameter int unsigned PA_W      = 40,
   localparam int unsigned IDX_W    = PAGE_BITS - 3,
   localparam int unsigned SEL_W    = (NUM_TTBR > 1) ? $clog2(NUM_TTBR) : 0,
   localparam int unsigned HI_W     = VA_W - PAGE_BITS - IDX_W,
   localparam int unsigned L1_IDX_W = HI_W - SEL_W
) (
   input  logic [HI_W-1:0]            va_hi,
   input  logic [NUM_TTBR*TTBR_W-1:0] ttbr_flat,
   output logic                       base_ok,
   output logic [PA_W-1:0]            l1_addr
);

   localparam int unsigned BASE_W = PA_W - 12;

   logic [TTBR_W-1:0]   ttbr_arr [NUM_TTBR];
   logic [TTBR_W-1:0]   ttbr_sel;
   logic [L1_IDX_W-1:0] l1_idx;

   for (genvar i = 0; i < NUM_TTBR; i++) begin : g_unpack
      assign ttbr_arr[i] = ttbr_flat[i*TTBR_W +: TTBR_W];
   end

   if (NUM_TTBR == 1) begin : g_one_base
      assign ttbr_sel = ttbr_arr[0];
   end else begin : g_many_base
      logic [SEL_W-1:0] sel;
      assign sel      = va_hi[HI_W-1 -: SEL_W];
      assign ttbr_sel = ttbr_arr[sel];
   end

   if (TTBR_W - 1 > BASE_W) begin : g_spare_bits
      logic unused_ttbr_gap;
      assign unused_ttbr_gap = ^ttbr_sel[TTBR_W-2:BASE_W];
   end

   assign l1_idx  = va_hi[L1_IDX_W-1:0];
   assign base_ok = ttbr_sel[TTBR_W-1];
   assign l1_addr = {ttbr_sel[BASE_W-1:0], 12'b0}
                  + {{(PA_W-L1_IDX_W-3){1'b0}}, l1_idx, 3'b000};

endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode #(
   parameter int unsigned PA_W      = 40,
   parameter int unsigned PAGE_BITS = 14,
   parameter int unsigned PA_SHIFT  = 4,
   localparam int unsigned IDX_W    = PAGE_BITS - 3,
   localparam int unsigned BND_W    = PAGE_BITS - 2,
   localparam int unsigned AW       = ptw_pkg::DESC_W - 2*BND_W,
   localparam int unsigned PFN_W    = PA_W - PAGE_BITS
) (
   input  logic [ptw_pkg::DESC_W-1:0] desc,
   input  logic [IDX_W-1:0]           l2_idx,
   input  logic [PAGE_BITS-1:0]       pg_off,
   output logic                       tbl_ok,
   output logic [PA_W-1:0]            next_addr,
   output logic                       leaf_ok,
   output logic [PA_W-1:0]            leaf_pa
);

   logic [PFN_W-1:0] pfn;
   logic [BND_W-1:0] lo_bnd, hi_bnd, off4;
   logic             in_range;

   // stored value is the physical address shifted right by PA_SHIFT
   assign pfn = desc[PA_W-PA_SHIFT-1 -: PFN_W];

   logic unused_low;
   assign unused_low = ^desc[PAGE_BITS-PA_SHIFT-1:2];

   if (PA_W - PA_SHIFT < AW) begin : g_addr_tail
      logic unused_high;
      assign unused_high = ^desc[AW-1:PA_W-PA_SHIFT];
   end

   assign lo_bnd   = desc[ptw_pkg::DESC_W-1 -: BND_W];
   assign hi_bnd   = desc[ptw_pkg::DESC_W-1-BND_W -: BND_W];
   assign off4     = pg_off[PAGE_BITS-1:2];
   assign in_range = (off4 >= lo_bnd) && (off4 <= hi_bnd);

   assign tbl_ok    = (desc[1:0] == 2'b11);
   assign next_addr = {pfn, l2_idx, 3'b000};
   assign leaf_ok   = desc[0] && (desc[1] || in_range);
   assign leaf_pa   = {pfn, pg_off};

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 40,
   parameter int unsigned PAGE_BITS = 14,
   parameter int unsigned NUM_TTBR  = 4,
   parameter int unsigned TTBR_W    = 32,
   parameter int unsigned PA_SHIFT  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_xlate_en,
   input  logic                       cfg_bypass,
   input  logic [NUM_TTBR*TTBR_W-1:0] cfg_ttbr,
   input  logic                       req_valid,
   input  logic [VA_W-1:0]            req_va,
   output logic                       req_ready,
   output logic                       busy,
   output logic                       mem_req,
   output logic [PA_W-1:0]            mem_addr,
   input  logic                       mem_gnt,
   input  logic                       mem_rvalid,
   input  logic [63:0]                mem_rdata,
   output logic                       rsp_valid,
   output logic                       rsp_fault,
   output logic [PA_W-1:0]            rsp_pa
);

   import ptw_pkg::*;

   localparam int unsigned IDX_W = PAGE_BITS - 3;
   localparam int unsigned HI_W  = VA_W - PAGE_BITS - IDX_W;

   if (PA_SHIFT != 0 && PA_SHIFT != 4) begin : g_bad_shift
      $error("PA_SHIFT must be 0 or 4");
   end
   if (PA_W < VA_W) begin : g_bad_pa
      $error("PA_W must cover VA_W for bypass");
   end
   if (PA_W > DESC_W - 2*(PAGE_BITS-2)) begin : g_bad_desc
      $error("PA_W exceeds descriptor address field");
   end
   if (PA_W - 12 > TTBR_W - 1) begin : g_bad_ttbr
      $error("base register too narrow for PA_W");
   end

   walk_state_e      state_q;
   logic [VA_W-1:0]  va_q;
   logic             byp_q;
   logic [PA_W-1:0]  addr_q;
   logic [PA_W-1:0]  pa_q;
   logic             fault_q;

   logic             base_ok, tbl_ok, leaf_ok;
   logic [PA_W-1:0]  l1_addr, next_addr, leaf_pa;
   logic             accept;

   ptw_va_split #(
      .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .NUM_TTBR(NUM_TTBR),
      .TTBR_W(TTBR_W), .PA_W(PA_W)
   ) u_split (
      .va_hi     (req_va[VA_W-1 -: HI_W]),
      .ttbr_flat (cfg_ttbr),
      .base_ok   (base_ok),
      .l1_addr   (l1_addr)
   );

   ptw_desc_decode #(
      .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PA_SHIFT(PA_SHIFT)
   ) u_dec (
      .desc      (mem_rdata),
      .l2_idx    (va_q[PAGE_BITS +: IDX_W]),
      .pg_off    (va_q[PAGE_BITS-1:0]),
      .tbl_ok    (tbl_ok),
      .next_addr (next_addr),
      .leaf_ok   (leaf_ok),
      .leaf_pa   (leaf_pa)
   );

   assign busy      = (state_q != ST_IDLE);
   assign req_ready = !busy;
   assign accept    = req_valid && !busy;
   assign mem_req   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign mem_addr  = addr_q;
   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_fault = fault_q;
   assign rsp_pa    = pa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         byp_q   <= 1'b0;
         addr_q  <= '0;
         pa_q    <= '0;
         fault_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               va_q  <= req_va;
               byp_q <= cfg_bypass;
               if (cfg_bypass) begin
                  pa_q    <= PA_W'(req_va);
                  fault_q <= 1'b0;
                  state_q <= ST_RESP;
               end else if (!cfg_xlate_en || !base_ok) begin
                  pa_q    <= '0;
                  fault_q <= 1'b1;
                  state_q <= ST_RESP;
               end else begin
                  addr_q  <= l1_addr;
                  state_q <= ST_L1_REQ;
               end
            end
            ST_L1_REQ: if (mem_gnt) state_q <= ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rvalid) begin
               if (tbl_ok) begin
                  addr_q  <= next_addr;
                  state_q <= ST_L2_REQ;
               end else begin
                  pa_q    <= '0;
                  fault_q <= 1'b1;
                  state_q <= ST_RESP;
               end
            end
            ST_L2_REQ: if (mem_gnt) state_q <= ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rvalid) begin
               fault_q <= !leaf_ok;
               pa_q    <= leaf_ok ? leaf_pa : '0;
               state_q <= ST_RESP;
            end
            ST_RESP: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R11
   single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   // R10
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   // R10
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[2:0] == 3'b000));

   // R3
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && byp_q) |-> (!rsp_fault && rsp_pa == PA_W'(va_q)));

   // R9
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

   // R9
   offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault) |-> (rsp_pa[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0]));

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_xlate_en = 1'b0;
   logic         cfg_bypass = 1'b0;
   logic [127:0] cfg_ttbr;
   logic         req_valid = 1'b0;
   logic [31:0]  req_va = '0;
   logic         req_ready, busy, mem_req;
   logic [39:0]  mem_addr;
   logic         mem_gnt = 1'b0;
   logic         mem_rvalid = 1'b0;
   logic [63:0]  mem_rdata = '0;
   logic         rsp_valid, rsp_fault;
   logic [39:0]  rsp_pa;

   logic [31:0]  tb_ttbr [4];
   int           n_chk = 0;
   int           n_bad = 0;

   always #4 clk = ~clk;

   assign cfg_ttbr = {tb_ttbr[3], tb_ttbr[2], tb_ttbr[1], tb_ttbr[0]};

   pt_walker dut (
      .clk(clk), .rst_n(rst_n), .cfg_xlate_en(cfg_xlate_en), .cfg_bypass(cfg_bypass),
      .cfg_ttbr(cfg_ttbr), .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
      .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [39:0] page_of(input logic [63:0] d);
      logic [43:0] w;
      w = {d[39:0], 4'b0};
      return w[39:0] & ~40'h3fff;
   endfunction

   function automatic logic [63:0] mk_l1(input logic [39:0] pa);
      return {24'b0, (pa >> 4)} | 64'h3;
   endfunction

   function automatic logic [63:0] mk_l2(input logic [39:0] pa, input logic [11:0] lo,
                                         input logic [11:0] hi, input bit full, input bit vld);
      return {lo, hi, (pa >> 4)} | {62'b0, full, vld};
   endfunction

   task automatic walk(input string tag, input logic [31:0] va, input bit byp, input bit en,
                       input logic [63:0] l1d, input logic [63:0] l2d,
                       input int gd, input int rd, input bit spam);
      bit          ef;
      logic [39:0] epa, a1, a2, tpa, pg;
      int          nexp;
      logic [31:0] t;
      logic [11:0] o4;
      int          cyc, nrd, phase, cnt;
      logic [39:0] seen [2];

      t = tb_ttbr[va[31:30]];
      a1 = '0; a2 = '0; ef = 1'b0; epa = '0; nexp = 0;
      if (byp) begin
         epa = {8'b0, va};
      end else if (!en || !t[31]) begin
         ef = 1'b1;
      end else begin
         nexp = 1;
         a1 = {t[27:0], 12'b0} + 40'(va[29:25]) * 40'd8;
         if (l1d[1:0] != 2'b11) ef = 1'b1;
         else begin
            nexp = 2;
            tpa = page_of(l1d);
            a2 = tpa + 40'(va[24:14]) * 40'd8;
            o4 = va[13:2];
            if (!l2d[0]) ef = 1'b1;
            else if (!l2d[1] && (o4 < l2d[63:52] || o4 > l2d[51:40])) ef = 1'b1;
            else begin
               pg = page_of(l2d);
               epa = pg | 40'(va[13:0]);
            end
         end
      end

      cfg_bypass = byp; cfg_xlate_en = en;
      req_va = va; req_valid = 1'b1;
      @(negedge clk);
      req_valid = spam; req_va = ~va;
      cyc = 0; nrd = 0; phase = 0; cnt = 0;
      while (!rsp_valid && cyc < 100) begin
         mem_gnt = 1'b0; mem_rvalid = 1'b0;
         if (phase == 0) begin
            if (mem_req) begin
               if (cnt == gd) begin
                  mem_gnt = 1'b1;
                  if (nrd < 2) seen[nrd] = mem_addr;
                  phase = 1; cnt = 0;
               end else cnt++;
            end
         end else begin
            if (cnt == rd) begin
               mem_rvalid = 1'b1;
               mem_rdata = (nrd == 0) ? l1d : l2d;
               nrd++; phase = 0; cnt = 0;
            end else cnt++;
         end
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0;
      chk(tag, "response seen", 64'(cyc < 100), 64'd1);
      chk(tag, "fault", 64'(rsp_fault), 64'(ef));
      chk(tag, "pa", 64'(rsp_pa), 64'(epa));
      chk("R10", "read count", 64'(nrd), 64'(nexp));
      if (nexp >= 1 && nrd >= 1) chk("R5", "first read address", 64'(seen[0]), 64'(a1));
      if (nexp >= 2 && nrd >= 2) chk("R6", "second read address", 64'(seen[1]), 64'(a2));
      chk("R2", "busy in response cycle", 64'(busy), 64'd1);
      @(negedge clk);
      chk("R11", "response lasts one cycle", 64'(rsp_valid), 64'd0);
      chk("R11", "ready after response", 64'(req_ready), 64'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [39:0] t2pa, pgpa;
      logic [63:0] l1g, l2g;
      logic [11:0] offs [8];
      offs = '{12'h000, 12'h0ff, 12'h100, 12'h101, 12'h1ff, 12'h200, 12'h201, 12'hfff};

      for (int i = 0; i < 4; i++) tb_ttbr[i] = {1'b1, 3'b0, 28'h0010000 + 28'(i * 'h40)};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "req_ready", 64'(req_ready), 64'd1);
      chk("R1", "busy", 64'(busy), 64'd0);
      chk("R1", "mem_req", 64'(mem_req), 64'd0);
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      t2pa = 40'h12_3456_C000;
      pgpa = 40'h87_6543_0000;
      l1g  = mk_l1(t2pa);
      l2g  = mk_l2(pgpa, 12'h000, 12'hfff, 1'b0, 1'b1);

      // R3 bypass, with and without enable
      for (int k = 0; k < 6; k++)
         walk("R3", 32'h9e37_79b9 * (k + 1), 1'b1, k[0], l1g, l2g, 0, 0, 1'b0);

      // R4 translation disabled
      for (int k = 0; k < 4; k++)
         walk("R4", {k[1:0], 30'h1234_567}, 1'b0, 1'b0, l1g, l2g, 0, 0, 1'b0);

      // R5 base select and valid flag sweep
      for (int s = 0; s < 4; s++)
         for (int v = 0; v < 2; v++) begin
            tb_ttbr[s][31] = v[0];
            walk("R5", {s[1:0], 5'(s * 7 + 3), 11'h2a5, 14'h1234}, 1'b0, 1'b1,
                 l1g, l2g, 0, 0, 1'b0);
            tb_ttbr[s][31] = 1'b1;
         end

      // R6 first-level type bits
      for (int ty = 0; ty < 4; ty++)
         walk("R6", 32'h4a5b_6c7d, 1'b0, 1'b1, {l1g[63:2], ty[1:0]}, l2g, 0, 0, 1'b0);

      // R7 invalid leaves
      walk("R7", 32'h0123_4567, 1'b0, 1'b1, l1g, 64'h0, 0, 0, 1'b0);
      walk("R7", 32'h0123_4567, 1'b0, 1'b1, l1g, mk_l2(pgpa, 12'h0, 12'hfff, 1'b1, 1'b0),
           0, 0, 1'b0);

      // R8 sub-page bounds sweep, full page on and off
      for (int f = 0; f < 2; f++)
         for (int o = 0; o < 8; o++)
            walk("R8", {18'h2_b3c4 >> 0, offs[o], o[1:0]}, 1'b0, 1'b1, l1g,
                 mk_l2(pgpa, 12'h100, 12'h200, f[0], 1'b1), 0, 0, 1'b0);

      // R9 several page addresses
      for (int k = 0; k < 5; k++)
         walk("R9", 32'h1357_9bdf + 32'(k * 32'h0452_1f0b), 1'b0, 1'b1,
              mk_l1(t2pa + 40'(k) * 40'h4000),
              mk_l2(pgpa ^ (40'(k) << 20), 12'h0, 12'hfff, k[0], 1'b1), 0, 0, 1'b0);

      // R10 grant and data latency sweep
      for (int g = 0; g < 3; g++)
         for (int r = 0; r < 3; r++)
            walk("R10", 32'h6d2f_a014 ^ 32'(g * 16 + r), 1'b0, 1'b1, l1g, l2g, g, r, 1'b0);

      // R2 request held high during walks, including the response cycle
      walk("R2", 32'h7777_1234, 1'b0, 1'b1, l1g, l2g, 1, 1, 1'b1);
      walk("R2", 32'h0bad_f00d, 1'b1, 1'b0, l1g, l2g, 0, 0, 1'b1);
      walk("R2", 32'h5555_aaaa, 1'b0, 1'b0, l1g, l2g, 0, 0, 1'b1);
      walk("R2", 32'h3141_5926, 1'b0, 1'b1, {l1g[63:2], 2'b01}, l2g, 2, 0, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule